// File: doc/BRIEF.md
# Four-Stage Universal Shift Register

A small synchronous register that holds a data word and, on each rising clock edge, either keeps it, moves it one place in either direction, or replaces it with a parallel word. A two-bit mode input picks the operation. Each shift direction has its own serial input, so a caller can feed a right-moving stream and a left-moving stream without multiplexing them outside the block.

Stage 0 is the head of a right shift: a right shift moves every bit one stage towards the highest index, and the right serial input enters stage 0. A left shift moves every bit towards stage 0, and the left serial input enters the highest stage. The two end stages double as serial outputs: `q_o[WIDTH-1]` is the bit leaving on a right shift, `q_o[0]` the bit leaving on a left shift. An active-low clear empties the register at once, without waiting for a clock, and wins over every other input. Tying the last stage back to the right serial input turns the block into a ring counter.

Top module: `univ_shreg`

## Requirements
- R1: With mode_i = 2'b00 the stored word does not change at a rising clock edge, whatever the serial and parallel inputs carry.
- R2: With mode_i = 2'b01 a rising edge gives q_o[0] = ser_right_i and q_o[i] = the previous q_o[i-1] for i = 1..WIDTH-1 (right shift).
- R3: With mode_i = 2'b10 a rising edge gives q_o[WIDTH-1] = ser_left_i and q_o[i] = the previous q_o[i+1] for i = 0..WIDTH-2 (left shift).
- R4: With mode_i = 2'b11 a rising edge copies par_i into q_o bit for bit, par_i[i] into q_o[i].
- R5: While rst_ni is 0 every bit of q_o is 0, and clock edges with any mode, serial or parallel value leave it 0.
- R6: A falling rst_ni clears q_o before any further clock edge arrives.
- R7: The first rising edge after rst_ni returns to 1 performs the selected mode normally.
- R8: With ser_right_i driven from q_o[WIDTH-1] and mode 2'b01, a single 1 loaded into stage 0 rotates one stage per clock and is back in stage 0 after WIDTH clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous clear, active low |
| mode_i | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 parallel load |
| ser_right_i | input | 1 | Serial bit entering stage 0 on a right shift |
| ser_left_i | input | 1 | Serial bit entering stage WIDTH-1 on a left shift |
| par_i | input | WIDTH | Parallel load word, bit i to stage i |
| q_o | output | WIDTH | Stored word; end stages serve as serial outputs |

## Verification
Clear and a clocked operation can coincide: the bench lowers rst_ni in the middle of a cycle while a load of all ones is selected, checks the word is already zero before the next edge, then lets an edge pass with the load still selected and expects zero again. The other overlap is the release of clear followed by an edge in the same cycle, provoked by raising rst_ni half a period before an edge with a load pending and judged by the loaded value appearing at once. Outside these, every mode is swept against all sixteen start words, every parallel word and both serial bits, with the expected word computed by shifting and masking.

// File: rtl/ushr_pkg.sv
package ushr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/ushr_next_sel.sv
module ushr_next_sel
  import ushr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  mode_e             mode_i,
  input  logic [WIDTH-1:0]  q_i,
  input  logic              ser_right_i,
  input  logic              ser_left_i,
  input  logic [WIDTH-1:0]  par_i,
  output logic [WIDTH-1:0]  d_o
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] from_lower;  // neighbour feeding each stage on a right shift
  logic [WIDTH-1:0] from_upper;  // neighbour feeding each stage on a left shift

  assign from_lower[0]    = ser_right_i;
  assign from_upper[LAST] = ser_left_i;

  for (genvar i = 1; i < WIDTH; i++) begin : g_lower
    assign from_lower[i] = q_i[i-1];
  end
  for (genvar i = 0; i < LAST; i++) begin : g_upper
    assign from_upper[i] = q_i[i+1];
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    always_comb begin
      unique case (mode_i)
        MODE_SHR:  d_o[i] = from_lower[i];
        MODE_SHL:  d_o[i] = from_upper[i];
        MODE_LOAD: d_o[i] = par_i[i];
        default:   d_o[i] = q_i[i];
      endcase
    end
  end
endmodule

// File: rtl/ushr_stage.sv
module ushr_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/univ_shreg.sv
module univ_shreg
  import ushr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             ser_right_i,
  input  logic             ser_left_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = WIDTH - 1;

  mode_e            mode;
  logic [WIDTH-1:0] d;

  assign mode = mode_e'(mode_i);

  ushr_next_sel #(.WIDTH(WIDTH)) i_next_sel (
    .mode_i      (mode),
    .q_i         (q_o),
    .ser_right_i (ser_right_i),
    .ser_left_i  (ser_left_i),
    .par_i       (par_i),
    .d_o         (d)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    ushr_stage i_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (d[i]),
      .q_o    (q_o[i])
    );
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> $stable(q_o)); // R1
  AST_SHIFT_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |=> q_o == {$past(q_o[LAST-1:0]), $past(ser_right_i)}); // R2
  AST_SHIFT_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> q_o == {$past(ser_left_i), $past(q_o[LAST:1])}); // R3
  AST_LOAD_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |=> q_o == $past(par_i)); // R4
  AST_CLEAR_EMPTY: assert property (@(posedge clk_i)
    !rst_ni |-> q_o == '0); // R5
endmodule

// File: tb/test_univ_shreg.sv
`timescale 1ns/1ps
module test_univ_shreg;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         sr_drv = 1'b0;
  logic         sl = 1'b0;
  logic [W-1:0] par = '0;
  logic [W-1:0] q;
  logic         ring_en = 1'b0;
  logic         sr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  assign sr = ring_en ? q[W-1] : sr_drv;

  univ_shreg #(.WIDTH(W)) i_univ_shreg (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ser_right_i(sr),
    .ser_left_i(sl), .par_i(par), .q_o(q)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b", req, q, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 200000);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] exp;
    repeat (2) @(negedge clk);
    check("R5 reset", '0);
    rst_n = 1'b1;

    // Sweep: start word, mode, serial bits, parallel word
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 4; m++)
        for (int b = 0; b < 4; b++)
          for (int p = 0; p < 16; p++) begin
            mode = 2'b11; par = W'(s);
            @(negedge clk);
            mode = 2'(m); sr_drv = b[0]; sl = b[1]; par = W'(p);
            @(negedge clk);
            case (m)
              0: begin exp = W'(s);                          check("R1 hold", exp); end
              1: begin exp = W'(((s << 1) | b[0]) & 15);     check("R2 right", exp); end
              2: begin exp = W'((s >> 1) | (b[1] << 3));     check("R3 left", exp); end
              default: begin exp = W'(p);                    check("R4 load", exp); end
            endcase
          end

    // Asynchronous clear mid-cycle, then edges while held
    mode = 2'b11; par = 4'b1111;
    @(negedge clk);
    check("R4 load ones", 4'b1111);
    @(posedge clk); #1;
    rst_n = 1'b0; #0.5;
    check("R6 async clear", '0);
    @(negedge clk);
    mode = 2'b11; par = 4'b1111;
    repeat (2) @(negedge clk);
    check("R5 clear overrides load", '0);
    mode = 2'b01; sr_drv = 1'b1;
    @(negedge clk);
    check("R5 clear overrides shift", '0);

    // Release half a period before an edge with a load pending
    mode = 2'b11; par = 4'b1010;
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 first edge after clear", 4'b1010);
    mode = 2'b10; sl = 1'b1;
    @(negedge clk);
    check("R7 follow-up left", 4'b1101);

    // Ring counter: single one in stage 0, feedback from last stage
    mode = 2'b11; par = 4'b0001;
    @(negedge clk);
    check("R8 ring seed", 4'b0001);
    ring_en = 1'b1; mode = 2'b01;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R8 ring rotate", W'(1 << (k % W)));
    end
    ring_en = 1'b0; mode = 2'b00;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule